// File: doc/BRIEF.md
# Watch Timebase with Buzzer Tap

This block is the watch timebase of a low-power controller. It turns a 32.768 kHz watch clock into a periodic watch tick. That is a 0.5 s interval in normal operation, or a 128 times faster interval for test. Each tick raises a sticky watch flag and emits a single-cycle interrupt pulse. The flag can also serve as a wake source for the standby logic that lies outside this block.

The watch clock comes from one of two places. One is a slow subsystem clock that already runs at 32.768 kHz. The other is a fast main clock, which passes through a divide-by-128 prescaler. Both arrive as level signals that are synchronous to the block clock `clk_i`, and their rising edges are detected inside the block. A 14-bit divider counts the watch-clock ticks. A low tap of this divider gives a fixed buzzer square wave, which a port stage can route to a pin. Software controls the block through a 4-bit mode register written over a simple write strobe, and it can clear the divider so that timekeeping starts again from zero.

Top module: `watch_timebase`

## Requirements
- R1: After reset the mode register is 0, and the watch flag, the interrupt pulse, `buz_pin_o` and `buz_oe_o` are all 0.
- R2: Mode bit 1 selects the tick source. With 0, every rising edge of `sub_clk_i` is one watch tick. With 1, one watch tick occurs for every 128 rising edges of `main_clk_i`, counted through a prescaler that restarts from zero whenever the divider is cleared or stopped.
- R3: With mode bit 2 = 0 (normal rate), an interrupt occurs on the 16384th watch tick after the divider starts from zero, and on every 16384th tick after that.
- R4: With mode bit 2 = 1 (fast rate), an interrupt occurs on every 128th watch tick counted from zero.
- R5: `wflag_o` is set at the same clock edge as each interrupt. It stays set until a clock edge that samples `flag_clr_i` high. When a clear and a new interrupt fall on the same edge, the flag ends up set.
- R6: `wirq_o` is high for exactly one cycle for each interrupt, and it is never high in two consecutive cycles.
- R7: The buzzer wave is low during watch ticks 0 to 7 of every 16-tick period and high during ticks 8 to 15, which gives the watch clock divided by 16. `buz_oe_o` follows `port_out_mode_i`. `buz_pin_o` is 0 when `port_out_mode_i` is 0. Otherwise it is the buzzer wave when mode bit 3 is 1, and `port_latch_i` when mode bit 3 is 0.
- R8: An edge that samples `div_clr_i` high resets the divider to zero. Any tick seen at that same edge is discarded, and counting resumes from zero.
- R9: With mode bit 0 = 0 the divider and the prescaler are held at zero, no ticks are counted and no interrupts occur. Writes through `mode_we_i` take effect from the edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sub_clk_i | input | 1 | Subsystem watch clock level, synchronous to clk_i |
| main_clk_i | input | 1 | Main clock level, synchronous to clk_i |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 4 | Mode data: bit0 run, bit1 main source, bit2 fast rate, bit3 buzzer enable |
| div_clr_i | input | 1 | Divider clear |
| flag_clr_i | input | 1 | Watch flag clear |
| port_out_mode_i | input | 1 | Buzzer port bit is in output mode |
| port_latch_i | input | 1 | Buzzer port output latch |
| wflag_o | output | 1 | Sticky watch flag |
| wirq_o | output | 1 | One-cycle watch interrupt pulse |
| buz_pin_o | output | 1 | Buzzer pin value |
| buz_oe_o | output | 1 | Buzzer pin output enable |

## Verification
The situation hardest to reach from the ports is the same edge carrying both a flag clear and a new interrupt, because the interrupt edge depends on the source-edge phase. The stimulus holds `flag_clr_i` high for a whole fast-rate period, so the coincidence cannot be missed. A bench model counts source edges, and the bench compares the flag against that model on every cycle. The main-clock path needs 16384 main edges for each fast tick. Its prescaler is therefore synchronised by writing the mode and clearing the divider at one edge, so that the interrupt count in a fixed window is exact.

// File: rtl/wtm_pkg.sv
package wtm_pkg;
  localparam int WT_DIV_W  = 14;
  localparam int WT_FAST_W = 7;
  localparam int WT_PRE_W  = 7;
  localparam int WT_BUZ    = 3;

  typedef struct packed {
    logic buz_en;
    logic fast;
    logic src_main;
    logic run;
  } wt_mode_t;

  // true when the low w bits of c are all ones (the next tick wraps them)
  function automatic logic low_bits_full(logic [WT_DIV_W-1:0] c, int unsigned w);
    logic [WT_DIV_W-1:0] m;
    m = (w >= WT_DIV_W) ? '1 : WT_DIV_W'((32'd1 << w) - 32'd1);
    return (c & m) == m;
  endfunction
endpackage

// File: rtl/wtm_edge.sv
module wtm_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/wtm_prescale.sv
module wtm_prescale #(
  parameter int PRE_W = wtm_pkg::WT_PRE_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic step_i,
  output logic carry_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (hold_i) pre_q <= '0;
    else if (step_i) pre_q <= pre_q + 1'b1;
  end

  assign carry_o = step_i & ~hold_i & (&pre_q);

  // R2: prescaler restarts from zero while held
  assert_pre_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (pre_q == '0));
endmodule

// File: rtl/wtm_divider.sv
module wtm_divider
  import wtm_pkg::*;
#(
  parameter int DIV_W  = WT_DIV_W,
  parameter int FAST_W = WT_FAST_W,
  parameter int BUZ    = WT_BUZ
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic tick_i,
  input  logic fast_i,
  output logic evt_o,
  output logic wave_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_hit = low_bits_full(WT_DIV_W'(cnt_q), fast_i ? FAST_W : DIV_W);
  assign evt_o    = tick_i & ~hold_i & wrap_hit;
  assign wave_o   = cnt_q[BUZ];

  assert_hold_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));
  assert_tick_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && tick_i) |=> (cnt_q == DIV_W'($past(cnt_q) + 1'b1)));
  assert_idle_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/watch_timebase.sv
module watch_timebase
  import wtm_pkg::*;
#(
  parameter int DIV_W  = WT_DIV_W,
  parameter int FAST_W = WT_FAST_W,
  parameter int PRE_W  = WT_PRE_W,
  parameter int BUZ    = WT_BUZ
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sub_clk_i,
  input  logic       main_clk_i,
  input  logic       mode_we_i,
  input  logic [3:0] mode_wdata_i,
  input  logic       div_clr_i,
  input  logic       flag_clr_i,
  input  logic       port_out_mode_i,
  input  logic       port_latch_i,
  output logic       wflag_o,
  output logic       wirq_o,
  output logic       buz_pin_o,
  output logic       buz_oe_o
);
  wt_mode_t   mode_q;
  logic [1:0] rise;
  logic       hold, main_tick, fw_tick, evt, wave;
  logic       flag_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= wt_mode_t'(mode_wdata_i);
  end

  wtm_edge #(.N(2)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lvl_i({main_clk_i, sub_clk_i}), .rise_o(rise)
  );

  assign hold = ~mode_q.run | div_clr_i;

  wtm_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold),
    .step_i(rise[1]), .carry_o(main_tick)
  );

  assign fw_tick = mode_q.src_main ? main_tick : rise[0];

  wtm_divider #(.DIV_W(DIV_W), .FAST_W(FAST_W), .BUZ(BUZ)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold), .tick_i(fw_tick),
    .fast_i(mode_q.fast), .evt_o(evt), .wave_o(wave)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= evt | (flag_q & ~flag_clr_i);
      irq_q  <= evt;
    end
  end

  assign wflag_o   = flag_q;
  assign wirq_o    = irq_q;
  assign buz_oe_o  = port_out_mode_i;
  assign buz_pin_o = port_out_mode_i & (mode_q.buz_en ? wave : port_latch_i);

  assert_irq_sets_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wirq_o |-> wflag_o);
  assert_irq_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wirq_o |=> !wirq_o);
  assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wflag_o && !flag_clr_i) |=> wflag_o);
  assert_stopped_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q.run |=> !wirq_o);
endmodule

// File: tb/watch_timebase_tb_top.sv
module watch_timebase_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sub_clk = 0, main_clk = 0, we = 0, dclr = 0, fclr = 0, omode = 0, latch = 0;
  logic [3:0] wdata = '0;
  logic wflag, wirq, bpin, boe;

  always #2 clk = ~clk;

  watch_timebase dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sub_clk_i(sub_clk), .main_clk_i(main_clk),
    .mode_we_i(we), .mode_wdata_i(wdata), .div_clr_i(dclr), .flag_clr_i(fclr),
    .port_out_mode_i(omode), .port_latch_i(latch),
    .wflag_o(wflag), .wirq_o(wirq), .buz_pin_o(bpin), .buz_oe_o(boe)
  );

  int n_vec = 0, n_bad = 0, irq_seen = 0, set_under_clr = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // source generators: sub period 4 cycles, main period 2 cycles
  int sub_cnt = 0;
  always @(negedge clk) begin
    main_clk <= ~main_clk;
    sub_cnt  <= (sub_cnt + 1) % 2;
    if (sub_cnt == 1) sub_clk <= ~sub_clk;
  end

  // reference model + scoreboard queue
  typedef struct packed { logic irq; logic flag; logic wave; logic fast; } exp_t;
  exp_t q[$];
  bit m_run, m_src, m_fast, m_buz, m_flag, m_sp, m_mp;
  int m_ticks, m_pre;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      {m_run, m_src, m_fast, m_buz, m_flag, m_sp, m_mp} = '0;
      m_ticks = 0; m_pre = 0;
    end else begin
      bit srise, mrise, tick, irq;
      exp_t e;
      srise = sub_clk && !m_sp; mrise = main_clk && !m_mp;
      m_sp = sub_clk; m_mp = main_clk;
      tick = 0; irq = 0;
      if (!m_run || dclr) begin
        m_ticks = 0; m_pre = 0;
      end else begin
        if (mrise) m_pre++;
        tick = m_src ? (mrise && m_pre % 128 == 0) : srise;
        if (tick) begin
          m_ticks++;
          irq = (m_ticks % (m_fast ? 128 : 16384)) == 0;
        end
      end
      m_flag = irq || (m_flag && !fclr);
      e.irq = irq; e.flag = m_flag; e.wave = (m_ticks / 8) % 2; e.fast = m_fast;
      if (we) {m_buz, m_fast, m_src, m_run} = wdata;
      q.push_back(e);
    end
  end

  bit prev_irq = 0;
  always @(posedge clk) begin
    #2;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      logic pexp;
      e = q.pop_front();
      chk(wirq == e.irq, e.fast ? "R4 irq" : "R3 irq", wirq, e.irq);
      chk(wflag == e.flag, "R5 flag", wflag, e.flag);
      pexp = omode & (m_buz ? e.wave : latch);
      chk(bpin == pexp, "R7 pin", bpin, pexp);
      chk(boe == omode, "R7 oe", boe, omode);
      if (wirq) begin
        irq_seen++;
        chk(!prev_irq, "R6 back-to-back", 1, 0);
        if (fclr) set_under_clr += wflag;
      end
      prev_irq = wirq;
    end
  end

  task automatic wr_mode(logic [3:0] v, bit clr);
    @(negedge clk); we = 1; wdata = v; dclr = clr;
    @(negedge clk); we = 0; dclr = 0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    run(5);
    chk({wflag, wirq, bpin, boe} == 4'b0, "R1 reset", {wflag, wirq, bpin, boe}, 0);
    rst_n = 1;
    run(3);
    chk({wflag, wirq, bpin, boe} == 4'b0, "R1 after release", {wflag, wirq, bpin, boe}, 0);

    // R4: fast rate from sub clock, 3 interrupts in 1600 cycles
    base = irq_seen;
    wr_mode(4'b0101, 1);
    run(1600);
    chk(irq_seen - base == 3, "R4 count", irq_seen - base, 3);

    // R5: clear the flag
    chk(wflag == 1, "R5 flag held", wflag, 1);
    @(negedge clk); fclr = 1; @(negedge clk); fclr = 0; run(1);
    chk(wflag == 0, "R5 cleared", wflag, 0);

    // R5: clear held across an interrupt edge - set wins
    set_under_clr = 0;
    @(negedge clk); fclr = 1; run(600); fclr = 0;
    chk(set_under_clr >= 1, "R5 set beats clear", set_under_clr, 1);

    // R7: buzzer routed to pin, then latch routing
    omode = 1;
    wr_mode(4'b1101, 0);
    run(300);
    latch = 1; wr_mode(4'b0101, 0); run(2);
    chk(bpin == 1, "R7 latch path", bpin, 1);
    omode = 0; run(1);
    chk(bpin == 0 && boe == 0, "R7 input mode", bpin, 0);
    omode = 1; latch = 0;

    // R8: divider clear restarts count; first irq 512 cycles later
    run(37);
    base = irq_seen;
    @(negedge clk); dclr = 1; @(negedge clk); dclr = 0;
    run(500);
    chk(irq_seen - base == 0, "R8 none before period", irq_seen - base, 0);
    run(20);
    chk(irq_seen - base == 1, "R8 one after period", irq_seen - base, 1);

    // R9: stopped divider
    base = irq_seen;
    wr_mode(4'b0100, 0);
    run(2000);
    chk(irq_seen - base == 0, "R9 stopped", irq_seen - base, 0);

    // R2: main source, fast rate: one irq per 32768 cycles
    base = irq_seen;
    wr_mode(4'b0111, 1);
    run(65636);
    chk(irq_seen - base == 2, "R2 main source count", irq_seen - base, 2);

    // R3: normal rate from sub clock, one irq per 65536 cycles
    base = irq_seen;
    wr_mode(4'b0001, 1);
    run(65736);
    chk(irq_seen - base == 1, "R3 normal count", irq_seen - base, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule